// File: doc/BRIEF.md
# Single-Format Accumulator Processor Core

This block is a compact multicycle processor core. Every instruction is one 16-bit word with a single layout. The top four bits carry the operation code. The next bit picks one of two working registers. The low eleven bits give a direct memory address. The core talks to one unified single-port memory. It presents an address, write data and a write strobe, and it receives read data one clock after it presents the address.

A small phase controller steps each instruction through fetch, decode, execute, an optional memory-read phase and an optional write-back phase. Opcodes that need no operand from memory return to fetch straight after execute. Subroutine linkage uses one hidden return-address register, so calls cannot nest. A halt opcode freezes the core until the next reset. A debug output shows the program counter at all times.

Top module: `mono_cpu`

## Requirements
- R1: A synchronous reset clears the program counter, both working registers, the return register and the halted flag. While reset is held, `dbg_pc` reads 0 and `halted` reads 0.
- R2: An instruction word is decoded as opcode = bits 15:12, register select = bit 11 and address = bits 10:0. The phases run fetch, then decode, then execute, in that order.
- R3: The binary operations ADD (0x0), SUB (0x1), AND (0x2), XOR (0x3) and OR (0x7) combine the selected register with the memory word at the address. The result goes back into that register. Arithmetic wraps modulo 2^16.
- R4: NOT (0x4) inverts the selected register. SHL (0x5) and SHR (0x6) shift it one bit with zero fill. The address field has no effect on the result of these three.
- R5: LDR (0x8) copies the memory word at the address into the selected register. STR (0x9) writes the selected register to that address, with `mem_we` high for exactly one cycle per store.
- R6: JMP (0xC) loads the program counter with the address field.
- R7: CALL (0xD) jumps to the address field and saves the address of the following instruction in the hidden return register. RET (0xB) jumps to the saved address.
- R8: JPOS (0xE) jumps only when the selected register has sign bit 0 and is nonzero. JZERO (0xF) jumps only when it is zero. When a condition fails, execution continues at the next instruction.
- R9: HALT (0xA) raises `halted`. After that the core issues no memory write and the program counter holds its value until reset.
- R10: Only the register named by the select bit is written. The other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 16 | Data to write to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_pc | output | 11 | Current program counter |

## Verification
The registers inside this core are seen only through stores, jumps and the program counter, so each test program ends by storing a register to memory and then halting. A corrupted register value, a wrong ALU result or a write to the wrong register shows up in the stored word a few cycles later, within the same short program. A bad program counter, a bad return address or a wrong branch decision sends execution down a different path. That path either changes which value gets stored or changes the final `dbg_pc` seen after the halt. A controller stuck outside its phase order never raises `halted`, and the per-program cycle limit catches that within a few thousand cycles.

// File: rtl/mono_pkg.sv
package mono_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_AND  = 4'h2,
      OP_XOR  = 4'h3,
      OP_NOT  = 4'h4,
      OP_SHL  = 4'h5,
      OP_SHR  = 4'h6,
      OP_OR   = 4'h7,
      OP_LDR  = 4'h8,
      OP_STR  = 4'h9,
      OP_HALT = 4'hA,
      OP_RET  = 4'hB,
      OP_JMP  = 4'hC,
      OP_CALL = 4'hD,
      OP_JPOS = 4'hE,
      OP_JZER = 4'hF
   } op_e;

   typedef enum logic [2:0] {
      PH_FETCH,
      PH_DECODE,
      PH_EXEC,
      PH_MEM,
      PH_WB,
      PH_STOP
   } phase_e;

   // Opcodes that need a word read from the address field
   function automatic logic needs_operand(op_e op);
      case (op)
         OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_OR, OP_LDR: needs_operand = 1'b1;
         default:                                       needs_operand = 1'b0;
      endcase
   endfunction

   // Opcodes that write the selected register straight from execute
   function automatic logic is_unary(op_e op);
      case (op)
         OP_NOT, OP_SHL, OP_SHR: is_unary = 1'b1;
         default:                is_unary = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/mono_alu.sv
module mono_alu
   import mono_pkg::*;
#(
   parameter int DW = 16
) (
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_XOR:  y = a ^ b;
         OP_OR:   y = a | b;
         OP_NOT:  y = ~a;
         OP_SHL:  y = {a[DW-2:0], 1'b0};
         OP_SHR:  y = {1'b0, a[DW-1:1]};
         OP_LDR:  y = b;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/mono_branch.sv
module mono_branch
   import mono_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 11
) (
   input  op_e           op,
   input  logic [DW-1:0] val,
   input  logic [AW-1:0] field_addr,
   input  logic [AW-1:0] link_addr,
   output logic          take,
   output logic [AW-1:0] dest
);

   logic is_zero;
   assign is_zero = (val == '0);

   always_comb begin
      take = 1'b0;
      dest = field_addr;
      case (op)
         OP_JMP, OP_CALL: take = 1'b1;
         OP_RET: begin
            take = 1'b1;
            dest = link_addr;
         end
         OP_JPOS: take = !val[DW-1] && !is_zero;
         OP_JZER: take = is_zero;
         default: take = 1'b0;
      endcase
   end

   // R8: a positive-branch decision never fires on a zero or negative word
   always_comb begin
      if (op == OP_JPOS && take) begin
         a_r8_pos_excludes_zero_neg: assert (!is_zero && !val[DW-1]);
      end
   end

endmodule

// File: rtl/mono_ctrl.sv
module mono_ctrl
   import mono_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  op_e    op,
   output phase_e phase
);

   phase_e nxt;

   always_comb begin
      nxt = phase;
      case (phase)
         PH_FETCH:  nxt = PH_DECODE;
         PH_DECODE: nxt = PH_EXEC;
         PH_EXEC: begin
            if (op == OP_HALT)          nxt = PH_STOP;
            else if (needs_operand(op)) nxt = PH_MEM;
            else                        nxt = PH_FETCH;
         end
         PH_MEM:    nxt = PH_WB;
         PH_WB:     nxt = PH_FETCH;
         PH_STOP:   nxt = PH_STOP;
         default:   nxt = PH_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) phase <= PH_FETCH;
      else     phase <= nxt;
   end

   a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
      phase == PH_FETCH |=> phase == PH_DECODE);

   a_r2_decode_then_exec: assert property (@(posedge clk) disable iff (rst)
      phase == PH_DECODE |=> phase == PH_EXEC);

   a_r9_stop_is_sticky: assert property (@(posedge clk) disable iff (rst)
      phase == PH_STOP |=> phase == PH_STOP);

endmodule

// File: rtl/mono_cpu.sv
module mono_cpu
   import mono_pkg::*;
#(
   parameter int DW   = 16,
   parameter int AW   = 11,
   parameter int OPW  = 4,
   parameter int SELW = 1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   input  logic [DW-1:0] mem_rdata,
   output logic          halted,
   output logic [AW-1:0] dbg_pc
);

   localparam int NREG   = 1 << SELW;
   localparam int SEL_LO = AW;
   localparam int OP_LO  = AW + SELW;

   generate
      if (OPW != 4) begin : g_bad_opw
         $error("mono_cpu: opcode field must be 4 bits");
      end
      if (OPW + SELW + AW != DW) begin : g_bad_fmt
         $error("mono_cpu: instruction fields must fill the data word");
      end
   endgenerate

   phase_e            phase;
   logic [AW-1:0]     pc;
   logic [AW-1:0]     link;
   logic [DW-1:0]     ir;
   logic [DW-1:0]     mdr;
   logic [DW-1:0]     gpr [NREG];
   op_e               ir_op;
   logic [SELW-1:0]   ir_sel;
   logic [AW-1:0]     ir_addr;
   logic [DW-1:0]     sel_val;
   logic [DW-1:0]     alu_y;
   logic              br_take;
   logic [AW-1:0]     br_dest;
   logic              in_exec;
   logic              reg_wr;

   assign ir_op   = op_e'(ir[OP_LO +: OPW]);
   assign ir_sel  = ir[SEL_LO +: SELW];
   assign ir_addr = ir[AW-1:0];
   assign sel_val = gpr[ir_sel];
   assign in_exec = (phase == PH_EXEC);

   mono_ctrl u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .op    (ir_op),
      .phase (phase)
   );

   mono_alu #(.DW(DW)) u_alu (
      .op (ir_op),
      .a  (sel_val),
      .b  (mdr),
      .y  (alu_y)
   );

   mono_branch #(.DW(DW), .AW(AW)) u_branch (
      .op         (ir_op),
      .val        (sel_val),
      .field_addr (ir_addr),
      .link_addr  (link),
      .take       (br_take),
      .dest       (br_dest)
   );

   // Memory port: fetch uses PC, every other phase uses the address field
   assign mem_addr  = (phase == PH_FETCH) ? pc : ir_addr;
   assign mem_wdata = sel_val;
   assign mem_we    = in_exec && (ir_op == OP_STR);
   assign dbg_pc    = pc;

   assign reg_wr = (in_exec && is_unary(ir_op)) || (phase == PH_WB);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc     <= '0;
         link   <= '0;
         ir     <= '0;
         mdr    <= '0;
         halted <= 1'b0;
      end else begin
         case (phase)
            PH_DECODE: begin
               ir <= mem_rdata;
               pc <= pc + 1'b1;
            end
            PH_EXEC: begin
               if (br_take)              pc     <= br_dest;
               if (ir_op == OP_CALL)     link   <= pc;
               if (ir_op == OP_HALT)     halted <= 1'b1;
            end
            PH_MEM:  mdr <= mem_rdata;
            default: ;
         endcase
      end
   end

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)                                     gpr[g] <= '0;
            else if (reg_wr && ir_sel == SELW'(g))       gpr[g] <= alu_y;
         end
      end
   endgenerate

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (pc == '0 && !halted));

   a_r9_no_write_halted: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);

   a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
      halted |=> $stable(pc));

   a_r5_store_one_cycle: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

   a_r6_jump_lands: assert property (@(posedge clk) disable iff (rst)
      (in_exec && ir_op == OP_JMP) |=> pc == $past(ir_addr));

   a_r7_link_is_next: assert property (@(posedge clk) disable iff (rst)
      (in_exec && ir_op == OP_CALL) |=> link == $past(pc));

   a_r8_zero_falls_through: assert property (@(posedge clk) disable iff (rst)
      (in_exec && ir_op == OP_JZER && sel_val != '0) |=> $stable(pc));

endmodule

// File: tb/mono_cpu_tb.sv
`timescale 1ns/1ps
module mono_cpu_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [10:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] mem_rdata;
   logic        halted;
   logic [10:0] dbg_pc;

   logic [15:0] mem [2048];
   int          total = 0;
   int          fails = 0;
   int          wr_cnt = 0;
   int          bad_wr = 0;

   always #2 clk = ~clk;

   mono_cpu u_dut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .halted    (halted),
      .dbg_pc    (dbg_pc)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
      if (!rst && mem_we) wr_cnt <= wr_cnt + 1;
      if (!rst && mem_we && halted) bad_wr <= bad_wr + 1;
   end

   function automatic logic [15:0] ins(logic [3:0] op, logic sel, logic [10:0] a);
      return {op, sel, a};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
   endtask

   task automatic run_prog(string tag);
      bit done;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      wr_cnt = 0;
      rst = 1'b0;
      done = 1'b0;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (halted) begin
            done = 1'b1;
            break;
         end
      end
      chk({tag, " reached halt R9"}, 32'(done), 32'd1);
   endtask

   // {opcode, initial register value, operand word, expected result}
   localparam logic [51:0] VEC [10] = '{
      {4'h0, 16'h1234, 16'h0F0F, 16'h2143},
      {4'h0, 16'hFFFF, 16'h0002, 16'h0001},
      {4'h1, 16'h0005, 16'h0007, 16'hFFFE},
      {4'h2, 16'hF0F0, 16'h3C3C, 16'h3030},
      {4'h3, 16'hF0F0, 16'h3C3C, 16'hCCCC},
      {4'h7, 16'hF0F0, 16'h0F01, 16'hFFF1},
      {4'h4, 16'h00FF, 16'h1234, 16'hFF00},
      {4'h5, 16'h8001, 16'h1234, 16'h0002},
      {4'h6, 16'h8001, 16'h1234, 16'h4000},
      {4'h8, 16'h1111, 16'hBEEF, 16'hBEEF}
   };

   task automatic run_branch(logic [3:0] op, logic [15:0] v, logic taken, string tag);
      clear_mem();
      mem[0]   = ins(4'h8, 1'b0, 11'd100);
      mem[1]   = ins(op,   1'b0, 11'd6);
      mem[2]   = ins(4'h8, 1'b1, 11'd101);
      mem[3]   = ins(4'h9, 1'b1, 11'd102);
      mem[4]   = ins(4'hA, 1'b0, 11'd0);
      mem[6]   = ins(4'h8, 1'b1, 11'd103);
      mem[7]   = ins(4'hC, 1'b0, 11'd3);
      mem[100] = v;
      mem[101] = 16'h0001;
      mem[103] = 16'h0002;
      run_prog(tag);
      chk(tag, 32'(mem[102]), taken ? 32'h2 : 32'h1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      // R1: reset state at the ports, then zeroed registers stored out
      clear_mem();
      mem[0]   = ins(4'h9, 1'b0, 11'd200);
      mem[1]   = ins(4'h9, 1'b1, 11'd201);
      mem[2]   = ins(4'hA, 1'b0, 11'd0);
      mem[200] = 16'hAAAA;
      mem[201] = 16'hBBBB;
      repeat (3) @(negedge clk);
      chk("R1 pc in reset", 32'(dbg_pc), 32'h0);
      chk("R1 halted in reset", 32'(halted), 32'h0);
      run_prog("R1");
      chk("R1 R0 cleared", 32'(mem[200]), 32'h0);
      chk("R1 R1 cleared", 32'(mem[201]), 32'h0);
      chk("R5 one strobe per store", 32'(wr_cnt), 32'd2);

      // R3 R4 R5: operation vectors through R0
      for (int i = 0; i < 10; i++) begin
         clear_mem();
         mem[0]   = ins(4'h8, 1'b0, 11'd100);
         mem[1]   = ins(VEC[i][51:48], 1'b0, 11'd101);
         mem[2]   = ins(4'h9, 1'b0, 11'd102);
         mem[3]   = ins(4'hA, 1'b0, 11'd0);
         mem[100] = VEC[i][47:32];
         mem[101] = VEC[i][31:16];
         run_prog("R3_R4_vec");
         chk($sformatf("R3 R4 R5 op %h", VEC[i][51:48]), 32'(mem[102]), 32'(VEC[i][15:0]));
      end

      // R10: select bit picks R1, R0 untouched
      clear_mem();
      mem[0]   = ins(4'h8, 1'b1, 11'd100);
      mem[1]   = ins(4'h0, 1'b1, 11'd101);
      mem[2]   = ins(4'h9, 1'b1, 11'd102);
      mem[3]   = ins(4'h9, 1'b0, 11'd103);
      mem[4]   = ins(4'hA, 1'b0, 11'd0);
      mem[100] = 16'd5;
      mem[101] = 16'd6;
      mem[103] = 16'h5555;
      run_prog("R10");
      chk("R10 selected R1 sum", 32'(mem[102]), 32'd11);
      chk("R10 R0 unchanged", 32'(mem[103]), 32'h0);

      // R6: jump skips a load
      clear_mem();
      mem[0]   = ins(4'hC, 1'b0, 11'd5);
      mem[1]   = ins(4'h8, 1'b0, 11'd100);
      mem[5]   = ins(4'h9, 1'b0, 11'd102);
      mem[6]   = ins(4'hA, 1'b0, 11'd0);
      mem[100] = 16'h7777;
      mem[102] = 16'h9999;
      run_prog("R6");
      chk("R6 skipped load", 32'(mem[102]), 32'h0);
      chk("R6 final pc", 32'(dbg_pc), 32'd7);

      // R7: call and return
      clear_mem();
      mem[0]   = ins(4'hD, 1'b0, 11'd10);
      mem[1]   = ins(4'h8, 1'b1, 11'd100);
      mem[2]   = ins(4'h9, 1'b1, 11'd102);
      mem[3]   = ins(4'hA, 1'b0, 11'd0);
      mem[10]  = ins(4'h8, 1'b0, 11'd101);
      mem[11]  = ins(4'h9, 1'b0, 11'd103);
      mem[12]  = ins(4'hB, 1'b0, 11'd0);
      mem[100] = 16'h00AB;
      mem[101] = 16'h0042;
      run_prog("R7");
      chk("R7 subroutine ran", 32'(mem[103]), 32'h42);
      chk("R7 returned after call", 32'(mem[102]), 32'hAB);
      chk("R7 final pc", 32'(dbg_pc), 32'd4);

      // R8: conditional jumps
      run_branch(4'hE, 16'h0005, 1'b1, "R8 jpos positive");
      run_branch(4'hE, 16'h0000, 1'b0, "R8 jpos zero");
      run_branch(4'hE, 16'h8000, 1'b0, "R8 jpos negative");
      run_branch(4'hF, 16'h0000, 1'b1, "R8 jzero zero");
      run_branch(4'hF, 16'h0003, 1'b0, "R8 jzero nonzero");

      // R9: halt freezes everything
      clear_mem();
      mem[0]  = ins(4'hA, 1'b0, 11'd0);
      mem[1]  = ins(4'h9, 1'b0, 11'd50);
      mem[50] = 16'h1234;
      run_prog("R9");
      repeat (20) @(negedge clk);
      chk("R9 halted stays", 32'(halted), 32'h1);
      chk("R9 pc frozen", 32'(dbg_pc), 32'd1);
      chk("R9 no store after halt", 32'(mem[50]), 32'h1234);
      chk("R9 no strobe while halted", 32'(bad_wr), 32'd0);

      // R1: reset releases a halted core
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 reset clears halted", 32'(halted), 32'h0);
      chk("R1 reset clears pc", 32'(dbg_pc), 32'h0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule